// File: doc/BRIEF.md
# SPI Command-Response Slave with Data-Ready Line

This block is an SPI target that never drives the serial clock. The bus controller frames each exchange by pulling an active-low select line and then clocks bytes in SPI mode 0: it samples its input on the rising SCLK edge, and the slave moves its output on the falling edge. The first byte of a frame is a command. While the command is being clocked in, the slave cannot know what will be asked, so it returns a status byte in that slot. The controller can keep this status byte as useful data.

The second byte carries the answer. For a read, the controller clocks a dummy byte and receives the contents of the selected register. For a write, the second byte is stored in the selected register. The register bank holds eight 8-bit registers. Register 0 is filled from a parallel post port. Whenever it holds data the controller has not yet read, a separate active-high line signals this, so the controller can be interrupted and start a transfer.

All serial inputs pass through two-flop synchronisers into the system clock domain. The system clock must therefore run several times faster than SCLK.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, `data_ready` is 0 and `miso` is 0. `miso` stays 0 whenever `cs_n` is high.
- R2: Bytes move MSB first. MOSI is sampled on rising SCLK and MISO is updated on falling SCLK. SCLK pulses while `cs_n` is high have no effect, and asserting `cs_n` restarts the bit count.
- R3: In the first byte of a frame, `miso` returns the status byte {data_ready, 6'b0, overflow}, captured when `cs_n` falls.
- R4: Command byte bit 7 = 1 means read, and bits 2:0 give the register address. In the second byte, `miso` returns that register's value as it stood when the command byte completed.
- R5: Command bit 7 = 0 means write. The second byte is stored in the addressed register when its eighth bit arrives. A write to address 0 is ignored. MOSI is ignored during the second byte of a read.
- R6: A pulse on `load_valid` stores `load_data` in register 0 and raises `data_ready`.
- R7: A post that arrives while `data_ready` is already 1 sets overflow. Overflow is never 1 while `data_ready` is 0.
- R8: Releasing `cs_n` after a frame that completed a read of register 0 clears both `data_ready` and overflow.
- R9: A frame released before its second byte completes writes no register and clears no flag.
- R10: A post in the same cycle as a clearing release takes priority. The clear is skipped, and overflow is set because `data_ready` was still 1.
- R11: Within a frame, `miso` changes only in response to a falling SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller (0 when not selected) |
| load_valid | input | 1 | Post strobe for register 0 |
| load_data | input | 8 | Value posted into register 0 |
| data_ready | output | 1 | High while register 0 holds unread data |

## Verification
Two functions can land in the same system-clock cycle: a new post on the parallel port, and the clearing that a completed register-0 read performs at select release. The bench raises `load_valid` on exactly the cycle in which the synchronised release takes effect, which is two clock edges after `cs_n` rises. It then judges the result at the ports. `data_ready` must stay high, the next status byte must show overflow, and the following read must return the newly posted value. Random frames are also mixed with posts between frames to exercise the ordinary paths.

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int W    = 8,
  parameter int NREG = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         mosi,
  output logic         miso,
  input  logic         load_valid,
  input  logic [W-1:0] load_data,
  output logic         data_ready
);
  localparam int AW = $clog2(NREG);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [2:0] sck_p, csn_p;
  logic [1:0] mosi_p;
  logic [CW-1:0] cnt;
  logic [1:0] phase;
  logic cmd_rd, arm, got2, ovf;
  logic [AW-1:0] cmd_a;
  logic [W-2:0] rx;
  logic [W-1:0] tx, nxt;
  logic [W-1:0] regs [NREG];

  wire cs_fe  = csn_p[2] & ~csn_p[1];
  wire cs_re  = ~csn_p[2] & csn_p[1];
  wire on     = ~csn_p[1] & ~csn_p[2];
  wire rise   = on & sck_p[1] & ~sck_p[2];
  wire fall   = on & ~sck_p[1] & sck_p[2];
  wire [W-1:0] rx_full = {rx, mosi_p[1]};
  wire [AW-1:0] rx_a   = rx_full[AW-1:0];

  assign miso = on ? tx[W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      csn_p  <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], sclk};
      csn_p  <= {csn_p[1:0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; phase <= '0; cmd_rd <= 1'b0; cmd_a <= '0;
      rx <= '0; tx <= '0; nxt <= '0;
      arm <= 1'b0; got2 <= 1'b0; data_ready <= 1'b0; ovf <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (cs_fe) begin
        cnt   <= '0;
        phase <= '0;
        got2  <= 1'b0;
        arm   <= 1'b0;
        tx    <= {data_ready, {(W-2){1'b0}}, ovf};
      end else if (rise) begin
        rx  <= rx_full[W-2:0];
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == LAST) begin
          case (phase)
            2'd0: begin
              cmd_rd <= rx_full[W-1];
              cmd_a  <= rx_a;
              nxt    <= regs[rx_a];
              arm    <= rx_full[W-1] && (rx_a == '0);
              phase  <= 2'd1;
            end
            2'd1: begin
              if (!cmd_rd && cmd_a != '0) regs[cmd_a] <= rx_full;
              got2  <= 1'b1;
              nxt   <= '0;
              phase <= 2'd2;
            end
            default: nxt <= '0;
          endcase
        end
      end else if (fall) begin
        tx <= (cnt == '0) ? nxt : {tx[W-2:0], 1'b0};
      end

      if (load_valid) begin
        regs[0]    <= load_data;
        ovf        <= ovf | data_ready;
        data_ready <= 1'b1;
        arm        <= 1'b0;
      end else if (cs_re && arm && got2) begin
        data_ready <= 1'b0;
        ovf        <= 1'b0;
      end
    end
  end

  // R7
  ovf_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> data_ready);

  // R7
  ovf_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(load_valid && data_ready));

  // R6
  ready_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(load_valid));

  // R8
  ready_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(cs_re && !load_valid));

  // R11
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && $past(on) && !$past(fall)) |-> $stable(miso));
endmodule

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, load_valid = 1'b0;
  logic [7:0] load_data = '0;
  logic miso, data_ready;
  int total = 0, bad = 0;

  logic [7:0] mreg [8];
  logic m_rdy = 1'b0, m_ovf = 1'b0;

  always #4 clk = ~clk;

  spi_cmd_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .load_valid(load_valid), .load_data(load_data),
    .data_ready(data_ready)
  );

  function automatic logic [7:0] stat_exp();
    return {m_rdy, 6'b0, m_ovf};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic post(input logic [7:0] d);
    @(negedge clk); load_valid = 1'b1; load_data = d;
    @(negedge clk); load_valid = 1'b0;
    if (m_rdy) m_ovf = 1'b1;
    m_rdy = 1'b1; mreg[0] = d;
    repeat (2) @(negedge clk);
    chk(data_ready === 1'b1, "R6 ready after post", data_ready, 1);
  endtask

  task automatic idle_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) sclk = 1'b1; repeat (HP) @(negedge clk);
      sclk = 1'b0; repeat (HP) @(negedge clk);
    end
  endtask

  task automatic frame(input logic [7:0] c, input logic [7:0] d, input int nb,
                       input bit pe, input logic [7:0] pd,
                       output logic [7:0] g0, output logic [7:0] g1);
    g0 = '0; g1 = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      mosi = (i < 8) ? c[7-i] : d[15-i];
      repeat (HP) @(negedge clk);
      if (i < 8) g0[7-i] = miso; else g1[15-i] = miso;
      sclk = 1'b1; repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    if (pe) begin
      @(posedge clk); @(posedge clk); @(negedge clk);
      load_valid = 1'b1; load_data = pd;
      @(negedge clk) load_valid = 1'b0;
    end
    repeat (10) @(negedge clk);
    chk(miso === 1'b0, "R1 miso idle", miso, 0);
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] d, input int nb,
                      input bit pe, input logic [7:0] pd);
    logic [7:0] g0, g1, e0, e1;
    logic [2:0] a;
    e0 = stat_exp();
    a = c[2:0];
    e1 = mreg[a];
    frame(c, d, nb, pe, pd, g0, g1);
    if (nb >= 8) chk(g0 === e0, "R3 status byte", g0, e0);
    if (nb >= 16 && c[7]) chk(g1 === e1, "R4 read data", g1, e1);
    if (nb >= 16 && !c[7] && a != 3'd0) mreg[a] = d;
    if (pe) begin
      if (m_rdy) m_ovf = 1'b1;
      m_rdy = 1'b1; mreg[0] = pd;
    end else if (nb >= 16 && c[7] && a == 3'd0) begin
      m_rdy = 1'b0; m_ovf = 1'b0;
    end
    chk(data_ready === m_rdy, "R8 R9 ready after frame", data_ready, m_rdy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(data_ready === 1'b0, "R1 reset ready", data_ready, 0);
    chk(miso === 1'b0, "R1 reset miso", miso, 0);

    // R3 R4 clean read
    xfer(8'h81, 8'h5A, 16, 1'b0, 8'h00);
    // R6 R7 post twice, status shows overflow
    post(8'hA5);
    xfer(8'h82, 8'h00, 16, 1'b0, 8'h00);
    post(8'h3C);
    xfer(8'h85, 8'h00, 16, 1'b0, 8'h00);
    // R9 short frames on register 0 read keep flags
    xfer(8'h80, 8'h00, 12, 1'b0, 8'h00);
    xfer(8'h80, 8'h00, 5, 1'b0, 8'h00);
    // R8 full read clears
    xfer(8'h80, 8'hFF, 16, 1'b0, 8'h00);
    // R5 write, then read back; write to 0 ignored; R9 short write discarded
    xfer(8'h03, 8'hC3, 16, 1'b0, 8'h00);
    xfer(8'h83, 8'h00, 16, 1'b0, 8'h00);
    xfer(8'h00, 8'hEE, 16, 1'b0, 8'h00);
    xfer(8'h80, 8'h77, 16, 1'b0, 8'h00);
    xfer(8'h06, 8'h99, 13, 1'b0, 8'h00);
    xfer(8'h86, 8'h00, 16, 1'b0, 8'h00);
    // R2 stray SCLK while deselected
    idle_pulses(3);
    xfer(8'h83, 8'h00, 16, 1'b0, 8'h00);
    idle_pulses(5);
    xfer(8'h03, 8'h4D, 16, 1'b0, 8'h00);
    xfer(8'h83, 8'h12, 16, 1'b0, 8'h00);
    // R10 post lands in the clearing cycle
    post(8'h11);
    xfer(8'h80, 8'h00, 16, 1'b1, 8'h22);
    chk(m_ovf === 1'b1, "R10 model overflow", m_ovf, 1);
    xfer(8'h80, 8'h00, 16, 1'b0, 8'h00);
    xfer(8'h81, 8'h00, 16, 1'b0, 8'h00);

    for (int it = 0; it < 60; it++) begin
      int sel;
      logic [7:0] c, d;
      sel = int'($urandom_range(0, 9));
      c = 8'($urandom); d = 8'($urandom);
      if (sel < 2) post(8'($urandom));
      else if (sel == 2) xfer(c, d, int'($urandom_range(1, 15)), 1'b0, 8'h00);
      else if (sel == 3) xfer({1'b1, 7'd0}, d, 16, 1'b0, 8'h00);
      else xfer(c, d, 16, 1'b0, 8'h00);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule